// File: doc/BRIEF.md
# Interrupt Status and Enable Front End

This block is the interrupt front end of a two-wire bus controller. Eight event lines from the controller core are captured into a sticky status register. An enable register masks the status bits, and one global enable bit gates the masked result. The block drives a single interrupt line. Software reads and clears the status through a small memory-mapped register window. It uses a one-cycle valid strobe with a write flag, an address and write data, and read data returns combinationally.

The same window holds a keyed soft-reset location. Writing the exact key value there produces a one-cycle reset pulse for the controller core. Any other value written there does nothing. The pulse leaves this block's own registers unchanged.

Top module: `intr_front_top`

## Requirements
- R1: After reset, status, enable and global enable are zero, `irqOut` is low and `coreReset` is low.
- R2: An event input sampled high at a clock edge sets its status bit after that edge, and the bit stays set until it is cleared. Bit meanings: 0 arbitration lost, 1 transmit error or transfer done, 2 transmit FIFO empty, 3 receive FIFO at threshold, 4 bus idle, 5 addressed as target, 6 no longer addressed as target, 7 transmit FIFO half empty.
- R3: A write to offset 0x20 clears every status bit whose write-data bit is one. Status bits written with zero keep their value.
- R4: Clearing takes priority over capture in the write cycle. An event line that is still high sets its bit again at the next edge.
- R5: Offset 0x28 holds an 8-bit enable mask in data bits 7:0. It reads back in those bits, and bits 31:8 read as zero.
- R6: Offset 0x1C holds the global enable in data bit 31. All other bits of that location read as zero.
- R7: `irqOut` is high exactly when the global enable is set and the bitwise AND of status and enable is non-zero.
- R8: A write of exactly 0x0000000A to offset 0x40 raises `coreReset` for the one cycle after the write edge. Status, enable and global enable are not affected.
- R9: A write of any other value to offset 0x40 leaves `coreReset` low. That location and any unmapped offset read as zero.
- R10: A read of offset 0x20 returns the status bits in data bits 7:0, with zeros above them.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regValid | input | 1 | Register access strobe, one cycle per access |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | 7 | Byte offset of the access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr`, combinational |
| eventIn | input | 8 | Event lines from the controller core |
| irqOut | output | 1 | Interrupt request |
| coreReset | output | 1 | One-cycle reset pulse to the controller core |

## Verification
Every register update is due at the first rising edge that samples the write strobe or the event level. `irqOut` follows in the same cycle, because it is combinational from those registers. `coreReset` is one registered stage, so it is high only in the cycle after the key write edge and low again at the next edge. The bench drives inputs on the falling edge and samples 1 ns after the rising edge. Each check therefore sees the value right after the edge under test and before the following edge. Level events are checked twice: once just after the clearing edge, and again after the next edge.

// File: rtl/intr_front_pkg.sv
package intr_front_pkg;
  // Register byte offsets within the window
  localparam int OFS_GLOBAL = 'h1C;
  localparam int OFS_STATUS = 'h20;
  localparam int OFS_ENABLE = 'h28;
  localparam int OFS_KEY    = 'h40;
  // Soft-reset key and global enable position
  localparam int RESET_KEY  = 'hA;
  localparam int GLOBAL_BIT = 31;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_GLOBAL, SEL_STATUS, SEL_ENABLE
  } regSel_e;

  typedef struct packed {
    logic    wrGlobal;
    logic    wrStatus;
    logic    wrEnable;
    logic    keyHit;
    regSel_e readSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/intr_front_ctrl.sv
module intr_front_ctrl
  import intr_front_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output ctrlStrobe_t       strobes
);
  logic isWrite;
  logic hitGlobal, hitStatus, hitEnable, hitKey;

  assign isWrite   = regValid && regWrite;
  assign hitGlobal = (regAddr == ADDR_W'(OFS_GLOBAL));
  assign hitStatus = (regAddr == ADDR_W'(OFS_STATUS));
  assign hitEnable = (regAddr == ADDR_W'(OFS_ENABLE));
  assign hitKey    = (regAddr == ADDR_W'(OFS_KEY));

  always_comb begin
    strobes.wrGlobal = isWrite && hitGlobal;
    strobes.wrStatus = isWrite && hitStatus;   // R3 write-one-clear
    strobes.wrEnable = isWrite && hitEnable;
    // R8 / R9: only the exact full-width key value is accepted
    strobes.keyHit   = isWrite && hitKey && (regWdata == DATA_W'(RESET_KEY));
    if (hitGlobal)      strobes.readSel = SEL_GLOBAL;
    else if (hitStatus) strobes.readSel = SEL_STATUS;
    else if (hitEnable) strobes.readSel = SEL_ENABLE;
    else                strobes.readSel = SEL_NONE;  // key reg reads zero
  end
endmodule

// File: rtl/intr_front_dp.sv
module intr_front_dp
  import intr_front_pkg::*;
#(
  parameter int EVENT_W = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobes,
  input  logic [EVENT_W-1:0] wrBits,
  input  logic               wrGlobalBit,
  input  logic [EVENT_W-1:0] eventIn,
  output logic [DATA_W-1:0]  regRdata,
  output logic               irqOut,
  output logic               coreReset,
  output logic [EVENT_W-1:0] statusVec,
  output logic [EVENT_W-1:0] enableVec,
  output logic               globalEn
);
  logic [EVENT_W-1:0] statusQ;
  logic [EVENT_W-1:0] enableQ;
  logic               globalQ;
  logic               coreResetQ;

  // R2 / R3 / R4: one sticky cell per event; clear wins in its cycle
  for (genvar b = 0; b < EVENT_W; b++) begin : gStatus
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 statusQ[b] <= 1'b0;
      else if (strobes.wrStatus) statusQ[b] <= statusQ[b] & ~wrBits[b];
      else                       statusQ[b] <= statusQ[b] | eventIn[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableQ    <= '0;
      globalQ    <= 1'b0;
      coreResetQ <= 1'b0;
    end else begin
      if (strobes.wrEnable) enableQ <= wrBits;
      if (strobes.wrGlobal) globalQ <= wrGlobalBit;
      coreResetQ <= strobes.keyHit;  // R8 one-cycle pulse
    end
  end

  // R7: global gate over the pending set
  assign irqOut    = globalQ && (|(statusQ & enableQ));
  assign coreReset = coreResetQ;

  always_comb begin
    regRdata = '0;
    unique case (strobes.readSel)
      SEL_GLOBAL: regRdata[GLOBAL_BIT]  = globalQ;
      SEL_STATUS: regRdata[EVENT_W-1:0] = statusQ;
      SEL_ENABLE: regRdata[EVENT_W-1:0] = enableQ;
      default:    regRdata = '0;
    endcase
  end

  assign statusVec = statusQ;
  assign enableVec = enableQ;
  assign globalEn  = globalQ;
endmodule

// File: rtl/intr_front_top.sv
module intr_front_top
  import intr_front_pkg::*;
#(
  parameter int EVENT_W = 8,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regValid,
  input  logic               regWrite,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [EVENT_W-1:0] eventIn,
  output logic               irqOut,
  output logic               coreReset
);
  ctrlStrobe_t        strobes;
  logic [EVENT_W-1:0] statusVec;
  logic [EVENT_W-1:0] enableVec;
  logic               globalEn;

  intr_front_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
    .regValid (regValid),
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobes  (strobes)
  );

  intr_front_dp #(.EVENT_W(EVENT_W), .DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrBits      (regWdata[EVENT_W-1:0]),
    .wrGlobalBit (regWdata[GLOBAL_BIT]),
    .eventIn     (eventIn),
    .regRdata    (regRdata),
    .irqOut      (irqOut),
    .coreReset   (coreReset),
    .statusVec   (statusVec),
    .enableVec   (enableVec),
    .globalEn    (globalEn)
  );
endmodule

// File: rtl/intr_front_chk.sv
module intr_front_chk
  import intr_front_pkg::*;
#(
  parameter int EVENT_W = 8,
  parameter int ADDR_W  = 7,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regValid,
  input logic               regWrite,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regWdata,
  input logic [EVENT_W-1:0] eventIn,
  input logic               irqOut,
  input logic               coreReset,
  input logic [EVENT_W-1:0] statusVec,
  input logic [EVENT_W-1:0] enableVec,
  input logic               globalEn
);
  logic clrWr, keyWr;
  assign clrWr = regValid && regWrite && (regAddr == ADDR_W'(OFS_STATUS));
  assign keyWr = regValid && regWrite && (regAddr == ADDR_W'(OFS_KEY));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    clrWr |=> ((statusVec & $past(regWdata[EVENT_W-1:0])) == '0));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((statusVec & $past(eventIn)) == $past(eventIn)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> ((statusVec & $past(statusVec)) == $past(statusVec)));

  assert_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    !globalEn |-> !irqOut);

  assert_pending_R7: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> ((statusVec & enableVec) != '0));

  assert_key_R8: assert property (@(posedge clk) disable iff (!rstN)
    (keyWr && regWdata == DATA_W'(RESET_KEY)) |=> coreReset);

  assert_badkey_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(keyWr && regWdata == DATA_W'(RESET_KEY)) |=> !coreReset);
endmodule

bind intr_front_top intr_front_chk #(
  .EVENT_W(EVENT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .regValid  (regValid),
  .regWrite  (regWrite),
  .regAddr   (regAddr),
  .regWdata  (regWdata),
  .eventIn   (eventIn),
  .irqOut    (irqOut),
  .coreReset (coreReset),
  .statusVec (statusVec),
  .enableVec (enableVec),
  .globalEn  (globalEn)
);

// File: tb/intr_front_top_tb_top.sv
`timescale 1ns/1ps
module intr_front_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regValid = 1'b0;
  logic        regWrite = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [7:0]  eventIn = '0;
  logic        irqOut;
  logic        coreReset;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  intr_front_top dut_i (
    .clk(clk), .rstN(rstN), .regValid(regValid), .regWrite(regWrite),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .eventIn(eventIn), .irqOut(irqOut), .coreReset(coreReset)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drives on falling edge, returns 1 ns after the capturing rising edge
  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    regValid = 1'b1; regWrite = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regValid = 1'b0; regWrite = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    regAddr = a; #0.5;
    d = regRdata;
  endtask

  task automatic pulse(input logic [7:0] v);
    @(negedge clk); eventIn = v;
    @(posedge clk); #1; eventIn = '0;
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] r;
    logic [7:0]  pat;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    rd(7'h20, r); check("R1 status", r, 0);
    rd(7'h28, r); check("R1 enable", r, 0);
    rd(7'h1C, r); check("R1 global", r, 0);
    check("R1 irq", irqOut, 0);
    check("R1 coreReset", coreReset, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;

    // R2 / R10 each event bit alone, sticky
    for (int b = 0; b < 8; b++) begin
      pulse(8'(1 << b));
      rd(7'h20, r); check("R2 capture", r, 32'(1 << b));
      @(posedge clk); #1;
      rd(7'h20, r); check("R2 sticky", r, 32'(1 << b));
      wr(7'h20, 32'hFF);
      rd(7'h20, r); check("R3 clear all", r, 0);
    end

    // R3 partial clear
    pulse(8'hFF);
    wr(7'h20, 32'h0000005A);
    rd(7'h20, r); check("R3 partial clear", r, 32'hA5);
    wr(7'h20, 32'h0);
    rd(7'h20, r); check("R3 zero write keeps", r, 32'hA5);
    wr(7'h20, 32'hFF);

    // R4 level source re-captures the cycle after clear
    @(negedge clk); eventIn = 8'h04;
    @(posedge clk); #1;
    wr(7'h20, 32'h04);
    rd(7'h20, r); check("R4 cleared on write edge", r, 0);
    @(posedge clk); #1;
    rd(7'h20, r); check("R4 recaptured next edge", r, 32'h04);
    @(negedge clk); eventIn = '0;
    wr(7'h20, 32'hFF);

    // R5 / R6 readback widths
    wr(7'h28, 32'hFFFFFFFF);
    rd(7'h28, r); check("R5 enable width", r, 32'hFF);
    wr(7'h1C, 32'h7FFFFFFF);
    rd(7'h1C, r); check("R6 other bits ignored", r, 0);
    wr(7'h1C, 32'hFFFFFFFF);
    rd(7'h1C, r); check("R6 global bit", r, 32'h80000000);
    wr(7'h1C, 32'h0);

    // R7 sweep: status patterns x all enable masks x global on/off
    for (int s = 0; s < 16; s++) begin
      pat = 8'(s * 17 + s);
      wr(7'h20, 32'hFF);
      pulse(pat);
      rd(7'h20, r); check("R10 status read", r, {24'h0, pat});
      for (int e = 0; e < 256; e++) begin
        wr(7'h28, 32'(e));
        check("R7 irq global off", irqOut, 0);
        wr(7'h1C, 32'h80000000);
        check("R7 irq global on", irqOut, ((pat & 8'(e)) != 0));
        wr(7'h1C, 32'h0);
      end
    end

    // R8 / R9 key sweep
    wr(7'h20, 32'hFF);
    pulse(8'h3C);
    wr(7'h28, 32'h81);
    for (int k = 0; k < 32; k++) begin
      wr(7'h40, 32'(k));
      check(k == 10 ? "R8 key pulse" : "R9 bad key ignored", coreReset, (k == 10));
      @(posedge clk); #1;
      check("R8 pulse one cycle", coreReset, 0);
    end
    wr(7'h40, 32'h1000000A);
    check("R9 upper bits break key", coreReset, 0);
    rd(7'h40, r); check("R9 key reads zero", r, 0);
    rd(7'h30, r); check("R9 unmapped reads zero", r, 0);
    rd(7'h20, r); check("R8 status kept", r, 32'h3C);
    rd(7'h28, r); check("R8 enable kept", r, 32'h81);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule